// File: doc/BRIEF.md
# Blocked VRAM DMA Controller

This controller copies data from system memory into the 8 KiB video RAM window in fixed blocks of 16 bytes. Software loads a source address and a destination offset through byte-wide registers, then writes a control byte that gives the block count and picks one of two modes. In bulk mode the whole transfer runs at once and the processor is held for its full length. In line mode the controller waits and copies exactly one block on each horizontal-blank strobe that arrives on a visible line. The processor runs freely between these blocks.

The controller reads a 16-bit word from the source and writes the same word to video RAM on every cycle of a block, so a block takes eight cycles. While a block is moving, `cpu_halt` is high. The control register reads back the progress of a transfer. When no transfer is running, or the last one finished, it reads all ones. A stopped line-mode transfer reads back its remaining count with the top bit set. The address registers step forward as blocks are copied, so a transfer that was stopped and then restarted continues from the next block.

Top module: `vram_block_dma`

## Requirements
- R1: After reset, `ctrl_rd` reads FFh, `cpu_halt` is low and neither memory enable is asserted.
- R2: `reg_sel` selects a register: 0 is the source high byte, 1 the source low byte, 2 the destination high byte, 3 the destination low byte and 4 the control byte. The low four bits of the source are always zero. Of the destination, only bits 12:4 are kept (high byte bits 4:0 and low byte bits 7:4). Every bus write address is 8000h plus that offset, so each block starts on a 16-byte boundary inside 8000h–9FFFh.
- R3: A block occupies 8 consecutive cycles. In beat k it reads the 16-bit word at source+2k and writes that word unchanged to destination+2k. The low byte belongs to the even address.
- R4: Bits 6:0 of a control write give the number of blocks minus one, so a transfer is 1 to 128 blocks (16 to 2048 bytes).
- R5: A control write with bit 7 = 0 starts bulk mode. `cpu_halt` goes high in the cycle after the write and stays high for exactly 8 × blocks cycles. The controller then goes idle and `ctrl_rd` reads FFh.
- R6: A control write with bit 7 = 1 starts line mode and copies nothing at first. Each `hblank` pulse with `line_num` below 144 starts one block. During that block `cpu_halt` is high for 8 cycles, and it is low again afterwards.
- R7: An `hblank` pulse starts nothing when `line_num` is 144 or more, or when no transfer is active.
- R8: While a transfer is active, `ctrl_rd` is {0, blocks remaining − 1}. This value drops by one after each block. After the last block, `ctrl_rd` reads FFh.
- R9: A control write with bit 7 = 0 during an active line-mode transfer stops it. `ctrl_rd` then reads {1, blocks remaining − 1}, and later `hblank` pulses copy nothing.
- R10: When a block has been written to the last destination slot (9FF0h–9FFFh), the transfer ends and `ctrl_rd` reads FFh, whatever count remains.
- R11: The source and destination advance by 16 bytes per block and are kept when a transfer stops. A restarted transfer resumes at the next block.
- R12: While a transfer is active, writes to the address registers are ignored, and so are control writes with bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (see R2) |
| reg_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register read value |
| hblank | input | 1 | One-cycle horizontal-blank strobe from display timing |
| line_num | input | 8 | Current display line |
| cpu_halt | output | 1 | Holds the processor while a block is copied |
| mem_rd_en | output | 1 | Source read enable |
| mem_rd_addr | output | 16 | Source byte address (even) |
| mem_rd_data | input | 16 | Source word, returned in the same cycle |
| mem_wr_en | output | 1 | Video RAM write enable |
| mem_wr_addr | output | 16 | Video RAM byte address (even) |
| mem_wr_data | output | 16 | Video RAM write word |

## Verification
The assertions assume three things about the inputs. The source memory answers a read in the same cycle. `hblank` is a single-cycle strobe. Register writes reach the controller only while `cpu_halt` is low, because the processor is stalled during a block. The stimulus drives every register write and every strobe through tasks that wait for `cpu_halt` to fall first, and it holds each strobe for exactly one cycle. Line numbers are drawn from both sides of the 144 boundary, and destinations are chosen either to stay inside the window or to land deliberately on its last slot.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } vdma_sel_e;

    typedef enum logic {
        MODE_BULK = 1'b0,
        MODE_LINE = 1'b1
    } vdma_mode_e;

endpackage

// File: rtl/vdma_addr_regs.sv
// Source and destination block pointers. Byte writes are folded into
// full-width images so that the forced-zero low bits fall out naturally.
module vdma_addr_regs
    import vdma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int VRAM_W    = 13,
    parameter int OFS_W     = 4,
    localparam int SRC_BLK_W = ADDR_W - OFS_W,
    localparam int DST_BLK_W = VRAM_W - OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [7:0]           reg_wdata,
    input  logic                 lock,
    input  logic                 advance,
    output logic [SRC_BLK_W-1:0] src_blk,
    output logic [DST_BLK_W-1:0] dst_blk,
    output logic                 dst_last
);

    typedef struct packed {
        logic [SRC_BLK_W-1:0] src;
        logic [DST_BLK_W-1:0] dst;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [ADDR_W-1:0] src_img;
    logic [ADDR_W-1:0] dst_img;

    always_comb begin
        ptr_d   = ptr_q;
        src_img = {ptr_q.src, {OFS_W{1'b0}}};
        dst_img = {{(ADDR_W-VRAM_W){1'b0}}, ptr_q.dst, {OFS_W{1'b0}}};
        if (advance) begin
            ptr_d.src = ptr_q.src + 1'b1;
            ptr_d.dst = ptr_q.dst + 1'b1;
        end else if (reg_wr && !lock) begin
            case (vdma_sel_e'(reg_sel))
                SEL_SRC_HI: src_img[ADDR_W-1 -: 8] = reg_wdata;
                SEL_SRC_LO: src_img[7:0]           = reg_wdata;
                SEL_DST_HI: dst_img[ADDR_W-1 -: 8] = reg_wdata;
                SEL_DST_LO: dst_img[7:0]           = reg_wdata;
                default: ;
            endcase
            ptr_d.src = src_img[ADDR_W-1:OFS_W];
            ptr_d.dst = dst_img[VRAM_W-1:OFS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign src_blk  = ptr_q.src;
    assign dst_blk  = ptr_q.dst;
    assign dst_last = &ptr_q.dst;

endmodule

// File: rtl/vdma_engine.sv
// Transfer sequencer: mode, remaining count, beat counter and halt.
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int LEN_W         = 7,
    parameter int BEATS         = 8,
    parameter int LINE_W        = 8,
    parameter int VISIBLE_LINES = 144,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              hblank,
    input  logic [LINE_W-1:0] line_num,
    input  logic              dst_last,
    output logic              copying,
    output logic [BEAT_W-1:0] beat,
    output logic              blk_done,
    output logic              active,
    output logic [LEN_W-1:0]  remain
);

    typedef struct packed {
        logic              active;
        vdma_mode_e        mode;
        logic              copying;
        logic [BEAT_W-1:0] beat;
        logic [LEN_W-1:0]  remain;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_beat;
    logic line_ok;

    assign last_beat = eng_q.copying && (eng_q.beat == BEAT_W'(BEATS - 1));
    assign line_ok   = line_num < LINE_W'(VISIBLE_LINES);

    always_comb begin
        eng_d = eng_q;
        if (eng_q.copying) begin
            eng_d.beat = eng_q.beat + 1'b1;
            if (last_beat) begin
                eng_d.beat = '0;
                if (eng_q.remain == '0 || dst_last) begin
                    eng_d.active  = 1'b0;
                    eng_d.copying = 1'b0;
                    eng_d.remain  = '1;
                end else begin
                    eng_d.remain  = eng_q.remain - 1'b1;
                    eng_d.copying = (eng_q.mode == MODE_BULK);
                end
            end
        end else if (ctrl_wr) begin
            if (!eng_q.active) begin
                eng_d.active  = 1'b1;
                eng_d.mode    = vdma_mode_e'(ctrl_wdata[7]);
                eng_d.remain  = ctrl_wdata[LEN_W-1:0];
                eng_d.beat    = '0;
                eng_d.copying = !ctrl_wdata[7];
            end else if (!ctrl_wdata[7]) begin
                // idle-while-active only happens in line mode: stop it
                eng_d.active = 1'b0;
            end
        end else if (eng_q.active && hblank && line_ok) begin
            eng_d.copying = 1'b1;
            eng_d.beat    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{active: 1'b0, mode: MODE_BULK, copying: 1'b0,
                       beat: '0, remain: '1};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign copying  = eng_q.copying;
    assign beat     = eng_q.beat;
    assign blk_done = last_beat;
    assign active   = eng_q.active;
    assign remain   = eng_q.remain;

endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
    import vdma_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int VRAM_W        = 13,
    parameter int VRAM_TAG      = 4,
    parameter int BLOCK_BYTES   = 16,
    parameter int BUS_BYTES     = 2,
    parameter int LEN_W         = 7,
    parameter int LINE_W        = 8,
    parameter int VISIBLE_LINES = 144,
    localparam int OFS_W     = $clog2(BLOCK_BYTES),
    localparam int LANE_W    = $clog2(BUS_BYTES),
    localparam int BEATS     = BLOCK_BYTES / BUS_BYTES,
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int TAG_W     = ADDR_W - VRAM_W,
    localparam int SRC_BLK_W = ADDR_W - OFS_W,
    localparam int DST_BLK_W = VRAM_W - OFS_W,
    localparam int DATA_W    = BUS_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        ctrl_rd,
    input  logic              hblank,
    input  logic [LINE_W-1:0] line_num,
    output logic              cpu_halt,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    logic [SRC_BLK_W-1:0] src_blk;
    logic [DST_BLK_W-1:0] dst_blk;
    logic                 dst_last;
    logic                 copying;
    logic [BEAT_W-1:0]    beat;
    logic                 blk_done;
    logic                 active;
    logic [LEN_W-1:0]     remain;
    logic                 ctrl_wr;

    assign ctrl_wr = reg_wr && (vdma_sel_e'(reg_sel) == SEL_CTRL);

    vdma_addr_regs #(
        .ADDR_W (ADDR_W),
        .VRAM_W (VRAM_W),
        .OFS_W  (OFS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .lock      (active),
        .advance   (blk_done),
        .src_blk   (src_blk),
        .dst_blk   (dst_blk),
        .dst_last  (dst_last)
    );

    vdma_engine #(
        .LEN_W         (LEN_W),
        .BEATS         (BEATS),
        .LINE_W        (LINE_W),
        .VISIBLE_LINES (VISIBLE_LINES)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata),
        .hblank     (hblank),
        .line_num   (line_num),
        .dst_last   (dst_last),
        .copying    (copying),
        .beat       (beat),
        .blk_done   (blk_done),
        .active     (active),
        .remain     (remain)
    );

    // control readback: top bit is "not running", remaining count below
    always_comb begin
        ctrl_rd = '1;
        ctrl_rd[7] = !active;
        ctrl_rd[LEN_W-1:0] = remain;
    end

    assign cpu_halt    = copying;
    assign mem_rd_en   = copying;
    assign mem_wr_en   = copying;
    assign mem_rd_addr = {src_blk, beat, {LANE_W{1'b0}}};
    assign mem_wr_addr = {TAG_W'(VRAM_TAG), dst_blk, beat, {LANE_W{1'b0}}};
    assign mem_wr_data = mem_rd_data;

endmodule

// File: rtl/vdma_checker.sv
module vdma_checker #(
    parameter int ADDR_W        = 16,
    parameter int LINE_W        = 8,
    parameter int VISIBLE_LINES = 144,
    parameter int BLOCK_BYTES   = 16,
    parameter int BUS_BYTES     = 2,
    localparam int OFS_W = $clog2(BLOCK_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic              hblank,
    input logic [LINE_W-1:0] line_num,
    input logic              cpu_halt,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [7:0]        ctrl_rd
);

    logic ctrl_write;
    assign ctrl_write = reg_wr && (reg_sel == 3'd4);

    AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> (mem_rd_addr[OFS_W-1:0] == '0) && (mem_wr_addr[OFS_W-1:0] == '0)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) && (mem_rd_addr[OFS_W-1:0] != '0)
        |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(BUS_BYTES)); // R3

    AST_HALT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> !ctrl_rd[7]); // R8

    AST_END_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_halt) && $rose(ctrl_rd[7]) |-> ctrl_rd == 8'hFF); // R10

    AST_OFFLINE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        hblank && (line_num >= LINE_W'(VISIBLE_LINES)) && !cpu_halt && !ctrl_write
        |=> !cpu_halt); // R7

    AST_COUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_halt) && !ctrl_rd[7] |-> ctrl_rd[6:0] == $past(ctrl_rd[6:0]) - 7'd1); // R8

endmodule

bind vram_block_dma vdma_checker #(
    .ADDR_W        (ADDR_W),
    .LINE_W        (LINE_W),
    .VISIBLE_LINES (VISIBLE_LINES),
    .BLOCK_BYTES   (BLOCK_BYTES),
    .BUS_BYTES     (BUS_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .hblank      (hblank),
    .line_num    (line_num),
    .cpu_halt    (cpu_halt),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_addr (mem_wr_addr),
    .ctrl_rd     (ctrl_rd)
);

// File: tb/vram_block_dma_test.sv
module vram_block_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  ctrl_rd;
    logic        hblank = 1'b0;
    logic [7:0]  line_num = 8'd0;
    logic        cpu_halt;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [15:0] mem_wr_data;

    int total = 0;
    int fails = 0;
    int wr_bytes = 0;
    int out_of_window = 0;
    logic [7:0] vram [0:8191];

    always #10 clk = ~clk;

    vram_block_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .hblank(hblank),
        .line_num(line_num), .cpu_halt(cpu_halt), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign mem_rd_data = {src_byte(mem_rd_addr + 16'd1), src_byte(mem_rd_addr)};

    always @(negedge clk) begin
        if (mem_wr_en) begin
            vram[mem_wr_addr[12:0]]        <= mem_wr_data[7:0];
            vram[mem_wr_addr[12:0] + 13'd1] <= mem_wr_data[15:8];
            wr_bytes <= wr_bytes + 2;
            if (mem_wr_addr[15:13] != 3'b100) out_of_window <= out_of_window + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] shi, input logic [7:0] slo,
                            input logic [7:0] dhi, input logic [7:0] dlo);
        wr_reg(3'd0, shi); wr_reg(3'd1, slo); wr_reg(3'd2, dhi); wr_reg(3'd3, dlo);
    endtask

    task automatic pulse(input logic [7:0] ln);
        @(negedge clk);
        hblank = 1'b1; line_num = ln;
        @(negedge clk);
        hblank = 1'b0;
    endtask

    task automatic count_halt(output int n);
        n = 0;
        while (cpu_halt && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int k, output int seen);
        seen = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (cpu_halt) seen++;
        end
    endtask

    function automatic int bad_bytes(input logic [11:0] sblk, input logic [8:0] dblk, input int nblk);
        int bad = 0;
        for (int b = 0; b < nblk; b++) begin
            for (int i = 0; i < 16; i++) begin
                logic [15:0] sa;
                logic [12:0] da;
                sa = {sblk + 12'(b), 4'(i)};
                da = {dblk + 9'(b), 4'(i)};
                if (vram[da] !== src_byte(sa)) bad++;
            end
        end
        return bad;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        int n, seen, w0, len;
        logic [11:0] sblk;
        logic [8:0]  dblk;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctrl_rd == 8'hFF, "R1 reset readback", ctrl_rd, 8'hFF);
        chk(!cpu_halt && !mem_rd_en && !mem_wr_en, "R1 reset idle", cpu_halt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // bulk: src 4000h, dst 8000h, 3 blocks
        set_addr(8'h40, 8'h00, 8'h00, 8'h00);
        wr_reg(3'd4, 8'h02);
        chk(mem_rd_addr == 16'h4000 && mem_wr_addr == 16'h8000, "R2 bulk start address", mem_wr_addr, 16'h8000);
        count_halt(n);
        chk(n == 24, "R5 bulk halt length", n, 24);
        chk(ctrl_rd == 8'hFF, "R5 bulk done readback", ctrl_rd, 8'hFF);
        chk(bad_bytes(12'h400, 9'h000, 3) == 0, "R3 bulk data", bad_bytes(12'h400, 9'h000, 3), 0);

        // line mode: masked addresses, 4 blocks
        set_addr(8'h12, 8'h3F, 8'hE4, 8'h5A);
        wr_reg(3'd4, 8'h83);
        chk(ctrl_rd == 8'h03, "R8 line active readback", ctrl_rd, 8'h03);
        idle_cycles(6, seen);
        chk(seen == 0, "R6 no copy before strobe", seen, 0);
        pulse(8'd144);
        idle_cycles(4, seen);
        chk(seen == 0 && ctrl_rd == 8'h03, "R7 line 144 ignored", ctrl_rd, 8'h03);
        pulse(8'd10);
        chk(mem_rd_addr == 16'h1230, "R2 source low nibble cleared", mem_rd_addr, 16'h1230);
        chk(mem_wr_addr == 16'h8450, "R2 destination bits 12:4", mem_wr_addr, 16'h8450);
        count_halt(n);
        chk(n == 8, "R6 one block per strobe", n, 8);
        chk(ctrl_rd == 8'h02, "R8 count decrement", ctrl_rd, 8'h02);
        // R12: writes while active are ignored
        wr_reg(3'd2, 8'h01);
        wr_reg(3'd3, 8'hF0);
        wr_reg(3'd4, 8'h85);
        chk(ctrl_rd == 8'h02, "R12 control bit7=1 ignored", ctrl_rd, 8'h02);
        pulse(8'd143);
        chk(mem_wr_addr == 16'h8460 && mem_rd_addr == 16'h1240, "R12 R11 address kept and advanced", mem_wr_addr, 16'h8460);
        count_halt(n);
        chk(n == 8 && ctrl_rd == 8'h01, "R6 second block", ctrl_rd, 8'h01);
        // R9 stop
        wr_reg(3'd4, 8'h00);
        chk(ctrl_rd == 8'h81, "R9 stopped readback", ctrl_rd, 8'h81);
        pulse(8'd5);
        idle_cycles(4, seen);
        chk(seen == 0 && ctrl_rd == 8'h81, "R9 strobe after stop", seen, 0);
        // R11 restart resumes
        wr_reg(3'd4, 8'h81);
        pulse(8'd0);
        chk(mem_rd_addr == 16'h1250 && mem_wr_addr == 16'h8470, "R11 resume address", mem_rd_addr, 16'h1250);
        count_halt(n);
        pulse(8'd20);
        count_halt(n);
        chk(ctrl_rd == 8'hFF, "R8 line done readback", ctrl_rd, 8'hFF);
        chk(bad_bytes(12'h123, 9'h045, 4) == 0, "R3 line data", bad_bytes(12'h123, 9'h045, 4), 0);
        pulse(8'd1);
        idle_cycles(4, seen);
        chk(seen == 0, "R7 strobe while idle", seen, 0);

        // R4 maximum length
        set_addr(8'h00, 8'h00, 8'h10, 8'h00);
        wr_reg(3'd4, 8'h7F);
        count_halt(n);
        chk(n == 1024, "R4 128 blocks", n, 1024);
        chk(bad_bytes(12'h000, 9'h100, 128) == 0, "R4 max data", 0, 0);

        // R10 destination overflow
        set_addr(8'h77, 8'h00, 8'h1F, 8'hF0);
        w0 = wr_bytes;
        wr_reg(3'd4, 8'h05);
        chk(mem_wr_addr == 16'h9FF0, "R10 last slot address", mem_wr_addr, 16'h9FF0);
        count_halt(n);
        chk(n == 8, "R10 early stop length", n, 8);
        chk(ctrl_rd == 8'hFF, "R10 early stop readback", ctrl_rd, 8'hFF);
        chk(wr_bytes - w0 == 16, "R10 bytes written", wr_bytes - w0, 16);

        // random bulk transfers
        for (int k = 0; k < 8; k++) begin
            sblk = 12'($urandom);
            dblk = 9'($urandom % 384);
            len  = int'($urandom % 16);
            set_addr(sblk[11:4], {sblk[3:0], 4'($urandom)},
                     {3'($urandom), dblk[8:4]}, {dblk[3:0], 4'($urandom)});
            wr_reg(3'd4, {1'b0, 7'(len)});
            count_halt(n);
            chk(n == 8 * (len + 1), "R5 R4 random bulk length", n, 8 * (len + 1));
            chk(bad_bytes(sblk, dblk, len + 1) == 0, "R3 random bulk data", bad_bytes(sblk, dblk, len + 1), 0);
        end
        chk(out_of_window == 0, "R2 writes inside window", out_of_window, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule